// File: doc/BRIEF.md
# Tile-Game Move Notation Formatter

This block turns one binary move, made of a column index, a row index and a two-bit tile code, into the text line a match host expects. The line is streamed one ASCII byte at a time towards a UART transmitter and always ends with a newline. The column comes first, written in bijective letters: column 0 is `@`, columns 1 to 26 are `A` to `Z`, and higher columns take two letters from `AA` onward. The row follows in decimal with no leading zeros. The tile symbol comes next, and the newline comes last.

A move is offered on `move_valid` with plain data pins and is taken only while `move_ready` is high, which happens only when the block is idle. Output bytes leave over a valid/ready stream. A byte stays on `byte_data` with `byte_valid` high until the downstream side raises `byte_ready` at a clock edge. Back-pressure of any length is allowed, and `byte_valid` never drops or changes data while it waits. After the newline is taken, `done` pulses for one cycle. The column split and the decimal digits are produced by small repeated-subtraction engines, so there is no divider.

Top module: `mvfmt_top`

## Requirements
- R1: `move_ready` is high only while idle. A move is taken on a clock edge where `move_valid` and `move_ready` are both high. A move offered while busy is not taken and does not alter the line in progress.
- R2: Column index 0 is written as the single byte `@` (0x40).
- R3: Column indices 1 to 26 are written as one letter, `A` + (col-1).
- R4: Column indices 27 to 702 are written as two letters. The first is `A` + ((col-1)/26 - 1) and the second is `A` + ((col-1) mod 26), so 27 gives `AA`, 53 gives `BA` and 702 gives `ZZ`. Indices above 702 are written as `ZZ`.
- R5: The row is written in decimal with no leading zeros. Row 0 is written as `0`.
- R6: Tile code 0 is written as `+` (0x2B), code 1 as `/` (0x2F), code 2 as `\` (0x5C), and code 3 as `+`.
- R7: The byte order on the stream is: column letters, row digits, tile symbol, newline (0x0A).
- R8: While `byte_valid` is high and `byte_ready` is low, `byte_valid` stays high and `byte_data` does not change on the next cycle.
- R9: `done` is high for exactly the one cycle after the edge that takes the newline. In that same cycle `move_ready` is high again.
- R10: While `rst_n` is low, and right after reset, `byte_valid` and `done` are low and `move_ready` is high. `byte_valid` is never high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| move_valid | input | 1 | A move is offered |
| move_ready | output | 1 | Block is idle and takes an offered move |
| move_col | input | COL_W | Column index |
| move_row | input | ROW_W | Row index |
| move_tile | input | 2 | Tile code (0 straight, 1 `/`, 2 `\`, 3 straight) |
| byte_valid | output | 1 | Output byte is present |
| byte_ready | input | 1 | Downstream takes the byte at this edge |
| byte_data | output | 8 | ASCII output byte |
| done | output | 1 | One-cycle pulse after the newline is taken |

## Verification
The bench builds the block with its defaults, COL_W = 10 and ROW_W = 10. With these widths the column input can reach past 702, so the `ZZ` clamp is exercised along with every letter-count boundary (0, 1, 26, 27, 52, 53, 702). A 10-bit row spans one to four digits, so leading-zero suppression is tested on rows with inner and trailing zeros (100, 1000) as well as on the maximum of 1023. Each line is received under continuous, alternating and sparse `byte_ready` patterns, so bytes are held for varying lengths of time.

// File: rtl/mvfmt_pkg.sv
package mvfmt_pkg;

  localparam int COL_MAX = 702;
  localparam int LETTERS = 26;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LET1,
    ST_LET2,
    ST_ROW,
    ST_TILE,
    ST_NL,
    ST_WAIT
  } fmt_state_t;

  function automatic int dec_digits(input int width);
    int v;
    int n;
    v = (1 << width) - 1;
    n = 1;
    while (v >= 10) begin
      v = v / 10;
      n = n + 1;
    end
    return n;
  endfunction

  function automatic logic [31:0] pow10(input int k);
    logic [31:0] p;
    p = 32'd1;
    for (int i = 0; i < k; i++) p = p * 32'd10;
    return p;
  endfunction

  function automatic logic [7:0] tile_char(input logic [1:0] code);
    case (code)
      2'd1:    return 8'h2F;
      2'd2:    return 8'h5C;
      default: return 8'h2B;
    endcase
  endfunction

endpackage

// File: rtl/mvfmt_colsplit.sv
module mvfmt_colsplit #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] col,
  output logic             rdy,
  output logic             is_at,
  output logic             two,
  output logic [4:0]       hi,
  output logic [4:0]       lo
);
  import mvfmt_pkg::*;

  logic [COL_W-1:0] rem_q;
  logic [COL_W-1:0] col_c;
  logic             busy_q;

  always_comb begin
    if (int'(col) > COL_MAX) col_c = COL_W'(COL_MAX);
    else                     col_c = col;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      hi     <= '0;
      busy_q <= 1'b0;
      rdy    <= 1'b0;
      is_at  <= 1'b0;
    end else if (start) begin
      is_at  <= (col_c == '0);
      rem_q  <= (col_c == '0) ? '0 : col_c - COL_W'(1);
      hi     <= '0;
      busy_q <= 1'b1;
      rdy    <= 1'b0;
    end else if (busy_q) begin
      if (int'(rem_q) >= LETTERS) begin
        rem_q <= rem_q - COL_W'(LETTERS);
        hi    <= hi + 5'd1;
      end else begin
        busy_q <= 1'b0;
        rdy    <= 1'b1;
      end
    end
  end

  assign two = (hi != 5'd0);
  assign lo  = rem_q[4:0];

endmodule

// File: rtl/mvfmt_rowdec.sv
module mvfmt_rowdec #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ROW_W-1:0] row,
  input  logic             take,
  output logic             dig_valid,
  output logic [3:0]       dig,
  output logic             last
);
  import mvfmt_pkg::*;

  localparam int DIGITS = dec_digits(ROW_W);
  localparam int PIDX_W = (DIGITS > 1) ? $clog2(DIGITS) : 1;

  typedef enum logic [1:0] {RD_IDLE, RD_CALC, RD_HOLD} rd_state_t;

  rd_state_t        st_q;
  logic [ROW_W-1:0] rem_q;
  logic [PIDX_W-1:0] pidx_q;
  logic [3:0]       q_q;
  logic             started_q;
  logic [31:0]      pw;

  always_comb pw = pow10(int'(pidx_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= RD_IDLE;
      rem_q     <= '0;
      pidx_q    <= '0;
      q_q       <= '0;
      started_q <= 1'b0;
    end else if (start) begin
      st_q      <= RD_CALC;
      rem_q     <= row;
      pidx_q    <= PIDX_W'(DIGITS - 1);
      q_q       <= '0;
      started_q <= 1'b0;
    end else begin
      case (st_q)
        RD_CALC: begin
          if (32'(rem_q) >= pw) begin
            rem_q <= rem_q - pw[ROW_W-1:0];
            q_q   <= q_q + 4'd1;
          end else if (q_q != 4'd0 || started_q || pidx_q == '0) begin
            st_q <= RD_HOLD;
          end else begin
            pidx_q <= pidx_q - PIDX_W'(1);
          end
        end
        RD_HOLD: begin
          if (take) begin
            started_q <= 1'b1;
            q_q       <= '0;
            if (pidx_q == '0) begin
              st_q <= RD_IDLE;
            end else begin
              pidx_q <= pidx_q - PIDX_W'(1);
              st_q   <= RD_CALC;
            end
          end
        end
        default: st_q <= RD_IDLE;
      endcase
    end
  end

  assign dig_valid = (st_q == RD_HOLD);
  assign dig       = q_q;
  assign last      = (pidx_q == '0);

endmodule

// File: rtl/mvfmt_txslot.sv
module mvfmt_txslot (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] din,
  input  logic       ready,
  output logic       valid,
  output logic [7:0] data,
  output logic       fire
);

  assign fire = valid && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= 8'h00;
    end else if (load) begin
      valid <= 1'b1;
      data  <= din;
    end else if (fire) begin
      valid <= 1'b0;
    end
  end

endmodule

// File: rtl/mvfmt_top.sv
module mvfmt_top #(
  parameter int COL_W = 10,
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             move_valid,
  output logic             move_ready,
  input  logic [COL_W-1:0] move_col,
  input  logic [ROW_W-1:0] move_row,
  input  logic [1:0]       move_tile,
  output logic             byte_valid,
  input  logic             byte_ready,
  output logic [7:0]       byte_data,
  output logic             done
);
  import mvfmt_pkg::*;

  fmt_state_t state_q, state_d;
  logic [1:0] tile_q;
  logic       accept;
  logic       cs_rdy, cs_at, cs_two;
  logic [4:0] cs_hi, cs_lo;
  logic       rd_valid, rd_last, rd_take;
  logic [3:0] rd_dig;
  logic       slot_load, slot_fire;
  logic [7:0] slot_din;

  assign move_ready = (state_q == ST_IDLE);
  assign accept     = move_valid && move_ready;

  mvfmt_colsplit #(.COL_W(COL_W)) u_col (
    .clk(clk), .rst_n(rst_n), .start(accept), .col(move_col),
    .rdy(cs_rdy), .is_at(cs_at), .two(cs_two), .hi(cs_hi), .lo(cs_lo)
  );

  mvfmt_rowdec #(.ROW_W(ROW_W)) u_row (
    .clk(clk), .rst_n(rst_n), .start(accept), .row(move_row),
    .take(rd_take), .dig_valid(rd_valid), .dig(rd_dig), .last(rd_last)
  );

  mvfmt_txslot u_slot (
    .clk(clk), .rst_n(rst_n), .load(slot_load), .din(slot_din),
    .ready(byte_ready), .valid(byte_valid), .data(byte_data), .fire(slot_fire)
  );

  always_comb begin
    state_d   = state_q;
    slot_load = 1'b0;
    slot_din  = 8'h00;
    rd_take   = 1'b0;
    case (state_q)
      ST_IDLE: if (accept) state_d = ST_LET1;
      ST_LET1: begin
        if (cs_rdy && !byte_valid) begin
          slot_load = 1'b1;
          if (cs_at) begin
            slot_din = 8'h40;
            state_d  = ST_ROW;
          end else if (cs_two) begin
            slot_din = 8'h40 + {3'd0, cs_hi};
            state_d  = ST_LET2;
          end else begin
            slot_din = 8'h41 + {3'd0, cs_lo};
            state_d  = ST_ROW;
          end
        end
      end
      ST_LET2: begin
        if (!byte_valid) begin
          slot_load = 1'b1;
          slot_din  = 8'h41 + {3'd0, cs_lo};
          state_d   = ST_ROW;
        end
      end
      ST_ROW: begin
        if (rd_valid && !byte_valid) begin
          slot_load = 1'b1;
          rd_take   = 1'b1;
          slot_din  = 8'h30 + {4'd0, rd_dig};
          if (rd_last) state_d = ST_TILE;
        end
      end
      ST_TILE: begin
        if (!byte_valid) begin
          slot_load = 1'b1;
          slot_din  = tile_char(tile_q);
          state_d   = ST_NL;
        end
      end
      ST_NL: begin
        if (!byte_valid) begin
          slot_load = 1'b1;
          slot_din  = 8'h0A;
          state_d   = ST_WAIT;
        end
      end
      ST_WAIT: if (slot_fire) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tile_q  <= 2'd0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= (state_q == ST_WAIT) && slot_fire;
      if (accept) tile_q <= move_tile;
    end
  end

endmodule

// File: rtl/mvfmt_chk.sv
module mvfmt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       move_valid,
  input logic       move_ready,
  input logic       byte_valid,
  input logic       byte_ready,
  input logic [7:0] byte_data,
  input logic       done
);

  function automatic logic legal_char(input logic [7:0] c);
    return (c >= 8'h40 && c <= 8'h5A) || (c >= 8'h30 && c <= 8'h39) ||
           c == 8'h2B || c == 8'h2F || c == 8'h5C || c == 8'h0A;
  endfunction

  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && !byte_ready |=> byte_valid && $stable(byte_data));

  p_take_leaves_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    move_valid && move_ready |=> !move_ready);

  p_done_after_nl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && byte_ready && byte_data == 8'h0A |=> done && move_ready);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    move_ready |-> !byte_valid);

  p_charset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> legal_char(byte_data));

endmodule

bind mvfmt_top mvfmt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .move_valid(move_valid), .move_ready(move_ready),
  .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
  .done(done)
);

// File: tb/sim_mvfmt_top.sv
module sim_mvfmt_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       move_valid = 1'b0;
  logic       move_ready;
  logic [9:0] move_col = '0;
  logic [9:0] move_row = '0;
  logic [1:0] move_tile = '0;
  logic       byte_valid;
  logic       byte_ready = 1'b0;
  logic [7:0] byte_data;
  logic       done;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #10 clk = ~clk;

  mvfmt_top #(.COL_W(10), .ROW_W(10)) u0 (
    .clk(clk), .rst_n(rst_n), .move_valid(move_valid), .move_ready(move_ready),
    .move_col(move_col), .move_row(move_row), .move_tile(move_tile),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
    .done(done)
  );

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  function automatic string expect_line(input int col, input int row, input int tile);
    string s;
    int c;
    c = (col > 702) ? 702 : col;
    if (c == 0) s = "@";
    else if (c <= 26) s = $sformatf("%c", 8'h40 + c);
    else s = $sformatf("%c%c", 8'h40 + (c - 1) / 26, 8'h41 + (c - 1) % 26);
    s = {s, $sformatf("%0d", row)};
    case (tile)
      1: s = {s, "/"};
      2: s = {s, "\\"};
      default: s = {s, "+"};
    endcase
    return {s, "\n"};
  endfunction

  // One scenario: offer a move, drain the line under a ready pattern, check it.
  task automatic run_move(input int col, input int row, input int tile,
                          input int mode, input bit intrude, input string tag);
    string exp_s, got;
    bit prev_hold, nl_seen, stab_ok, done_ok, busy_ok;
    logic [7:0] prev_data;
    exp_s = expect_line(col, row, tile);
    got = "";
    prev_hold = 0; nl_seen = 0; stab_ok = 1; done_ok = 1; busy_ok = 1;
    prev_data = 8'h00;
    @(negedge clk);
    while (!move_ready) @(negedge clk);
    move_valid = 1'b1;
    move_col = 10'(col); move_row = 10'(row); move_tile = 2'(tile);
    @(negedge clk);
    move_valid = 1'b0;
    if (intrude) begin
      move_valid = 1'b1; move_col = 10'd5; move_row = 10'd7; move_tile = 2'd1;
    end
    for (int i = 0; i < 4000; i++) begin
      if (intrude && i == 3) move_valid = 1'b0;
      if (intrude && i < 3 && move_ready) busy_ok = 0;
      if (prev_hold && !(byte_valid && byte_data == prev_data)) stab_ok = 0;
      if (nl_seen) begin
        if (!(done && move_ready)) done_ok = 0;
        break;
      end
      if (done) done_ok = 0;
      case (mode)
        0: byte_ready = 1'b1;
        1: byte_ready = (i % 2) == 1;
        default: byte_ready = (i % 7) == 6;
      endcase
      if (byte_valid && byte_ready) begin
        got = $sformatf("%s%c", got, byte_data);
        if (byte_data == 8'h0A) nl_seen = 1;
      end
      prev_hold = byte_valid && !byte_ready;
      prev_data = byte_data;
      @(negedge clk);
    end
    byte_ready = 1'b0;
    check(got == exp_s, tag, got, exp_s);
    check(stab_ok, "R8 hold", $sformatf("%0d", stab_ok), "1");
    check(done_ok && nl_seen, "R9 done", $sformatf("%0d", done_ok && nl_seen), "1");
    if (intrude) check(busy_ok, "R1 busy", $sformatf("%0d", busy_ok), "1");
    @(negedge clk);
    check(!done, "R9 single", $sformatf("%0d", done), "0");
  endtask

  task automatic test_reset;
    @(negedge clk);
    check(!byte_valid, "R10 valid", $sformatf("%0d", byte_valid), "0");
    check(!done, "R10 done", $sformatf("%0d", done), "0");
    check(move_ready, "R10 ready", $sformatf("%0d", move_ready), "1");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(move_ready && !byte_valid, "R10 after", $sformatf("%0d", move_ready), "1");
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    test_reset();
    run_move(0,    0,    1, 0, 0, "R2/R5/R6/R7 first move");
    run_move(1,    9,    0, 1, 0, "R3/R5 col 1");
    run_move(26,   10,   2, 2, 0, "R3/R6 col 26");
    run_move(27,   100,  3, 0, 0, "R4/R6 col 27 tile 3");
    run_move(52,   1000, 1, 1, 0, "R4/R5 col 52");
    run_move(53,   1023, 2, 2, 0, "R4/R5 col 53");
    run_move(702,  40,   0, 0, 1, "R4/R1 col 702 intrude");
    run_move(1000, 7,    1, 1, 0, "R4 clamp");
    run_move(13,   305,  2, 2, 1, "R1/R5 busy move ignored");
    run_move(0,    1,    0, 0, 0, "R2/R7 back to back");
    finish_run();
  end

endmodule